// File: doc/BRIEF.md
# Predicated Vector Compare Against Immediate

This unit takes one wide vector operand, splits it into lanes of 8, 16, 32 or 64 bits, and compares every lane with a single small immediate under one of ten conditions. It writes a destination predicate that holds one bit per vector byte. A per-byte governing predicate picks which lanes take part. Lanes that are switched off by the governing predicate always read as false.

Alongside the predicate, the unit returns four condition flags. They report:
- the result of the first participating lane;
- whether no participating lane came out true;
- the inverse of the result of the last participating lane;
- a fourth flag that is always cleared.

Inputs are sampled on a rising clock edge, and all outputs are registered, so results appear one cycle later. Instruction decode and register-file access are handled elsewhere. This unit only evaluates the compare.

Top module: `vcmp_imm`

## Requirements
- R1: `size_i` selects the lane width as 8 shifted left by the code (0 gives 8, 1 gives 16, 2 gives 32, 3 gives 64 bits). There are VLEN divided by that width lanes, and lane 0 occupies the least significant bits.
- R2: `cond_i` encodes the condition as 0 equal, 1 not equal, 2 signed greater, 3 signed greater-or-equal, 4 signed less, 5 signed less-or-equal, 6 unsigned higher, 7 unsigned higher-or-same, 8 unsigned lower, 9 unsigned lower-or-same. Codes 10 to 15 make every lane false.
- R3: Codes 0 to 5 read the lane as two's complement and compare it with `imm_i[4:0]` sign-extended to the lane width (range -16 to 15). Bits `imm_i[6:5]` have no effect for these codes.
- R4: Codes 6 to 9 read the lane as unsigned and compare it with `imm_i[6:0]` zero-extended (range 0 to 127).
- R5: A lane is active only when the governing bit at the lowest byte of that lane is 1. Governing bits at the lane's other bytes have no effect.
- R6: An active lane places its compare result in the lowest bit of its byte slice in `pred_o`, and every other bit of that slice is 0. An inactive lane's whole slice is 0.
- R7: `flag_n_o` equals the result of the lowest-numbered active lane.
- R8: `flag_z_o` is 1 exactly when no active lane is true.
- R9: `flag_c_o` is the inverse of the result of the highest-numbered active lane, and `flag_v_o` is always 0.
- R10: With no active lane, `pred_o` is all zeros, `flag_n_o` is 0, and `flag_z_o` and `flag_c_o` are 1.
- R11: Outputs reflect the inputs sampled at the previous rising edge. While `rst_n` is low, `pred_o` is 0, `flag_n_o` and `flag_v_o` are 0, and `flag_z_o` and `flag_c_o` are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| vec_i | input | VLEN | Vector operand |
| gov_i | input | VLEN/8 | Governing predicate, one bit per byte |
| size_i | input | 2 | Lane width code |
| cond_i | input | 4 | Condition code |
| imm_i | input | 7 | Immediate field |
| pred_o | output | VLEN/8 | Destination predicate, one bit per byte |
| flag_n_o | output | 1 | First active lane result |
| flag_z_o | output | 1 | No active lane true |
| flag_c_o | output | 1 | Inverse of last active lane result |
| flag_v_o | output | 1 | Always 0 |

## Verification
The only state is the output register, so any internal fault shows at the ports exactly one cycle after the inputs that caused it.

Some faults are visible without a reference model, because the outputs contradict each other in the same cycle:
- a predicate bit set outside a lane's lowest byte;
- a result left on a masked lane;
- a zero flag that disagrees with the predicate;
- a first-lane flag that disagrees with the zero flag.

Errors that stay internally consistent need a reference. These include a wrong sign or zero extension of the immediate and a wrong lane pick for the first or last flag. The bench catches them by comparing against an independent model, with 64-bit lanes and boundary immediates exposing the extension faults.

// File: rtl/vcmp_imm.sv
module vcmp_imm #(
  parameter int VLEN = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VLEN-1:0]   vec_i,
  input  logic [VLEN/8-1:0] gov_i,
  input  logic [1:0]        size_i,
  input  logic [3:0]        cond_i,
  input  logic [6:0]        imm_i,
  output logic [VLEN/8-1:0] pred_o,
  output logic              flag_n_o,
  output logic              flag_z_o,
  output logic              flag_c_o,
  output logic              flag_v_o
);
  localparam int PB = VLEN / 8;

  logic [PB-1:0] sz_hit [4];
  logic [PB-1:0] hit_c;
  logic [PB-1:0] act_c;
  logic [2:0]    base_msk;
  logic          fn_c, fz_c, fc_c;

  for (genvar gs = 0; gs < 4; gs++) begin : g_sz
    localparam int EW  = 8 << gs;
    localparam int LN  = VLEN / EW;
    localparam int BPL = EW / 8;
    logic [PB-1:0] hit;
    for (genvar gl = 0; gl < LN; gl++) begin : g_ln
      logic [EW-1:0] x, ks, ku;
      logic eq_s, lt_s, eq_u, lt_u, r;
      assign x    = vec_i[gl*EW +: EW];
      assign ks   = {{(EW-5){imm_i[4]}}, imm_i[4:0]};
      assign ku   = {{(EW-7){1'b0}}, imm_i};
      assign eq_s = (x == ks);
      assign lt_s = ($signed(x) < $signed(ks));
      assign eq_u = (x == ku);
      assign lt_u = (x < ku);
      always_comb begin
        case (cond_i)
          4'd0:    r = eq_s;
          4'd1:    r = !eq_s;
          4'd2:    r = !lt_s && !eq_s;
          4'd3:    r = !lt_s;
          4'd4:    r = lt_s;
          4'd5:    r = lt_s || eq_s;
          4'd6:    r = !lt_u && !eq_u;
          4'd7:    r = !lt_u;
          4'd8:    r = lt_u;
          4'd9:    r = lt_u || eq_u;
          default: r = 1'b0;
        endcase
      end
      assign hit[gl*BPL] = r & gov_i[gl*BPL];
      if (BPL > 1) begin : g_pad
        assign hit[gl*BPL+1 +: BPL-1] = '0;
      end
    end
    assign sz_hit[gs] = hit;
  end

  assign hit_c    = sz_hit[size_i];
  assign base_msk = 3'((4'd1 << size_i) - 4'd1);

  always_comb begin
    for (int b = 0; b < PB; b++)
      act_c[b] = gov_i[b] && ((3'(b) & base_msk) == 3'd0);
  end

  always_comb begin
    logic seen, lastv;
    seen  = 1'b0;
    lastv = 1'b0;
    fn_c  = 1'b0;
    for (int b = 0; b < PB; b++) begin
      if (act_c[b]) begin
        if (!seen) fn_c = hit_c[b];
        seen  = 1'b1;
        lastv = hit_c[b];
      end
    end
    fz_c = ~|hit_c;
    fc_c = ~lastv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_o   <= '0;
      flag_n_o <= 1'b0;
      flag_z_o <= 1'b1;
      flag_c_o <= 1'b1;
      flag_v_o <= 1'b0;
    end else begin
      pred_o   <= hit_c;
      flag_n_o <= fn_c;
      flag_z_o <= fz_c;
      flag_c_o <= fc_c;
      flag_v_o <= 1'b0;
    end
  end
endmodule

// File: rtl/vcmp_imm_chk.sv
module vcmp_imm_chk #(
  parameter int VLEN = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic [VLEN/8-1:0] gov_i,
  input logic [1:0]        size_i,
  input logic [VLEN/8-1:0] pred_o,
  input logic              flag_n_o,
  input logic              flag_z_o,
  input logic              flag_c_o,
  input logic              flag_v_o
);
  localparam int PB = VLEN / 8;
  logic [PB-1:0] lane_base;

  always_comb begin
    for (int b = 0; b < PB; b++)
      lane_base[b] = ((b % (1 << size_i)) == 0);
  end

  assert_v_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_v_o);

  assert_z_matches_pred_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_z_o == (pred_o == '0));

  assert_slice_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pred_o & ~($past(gov_i) & $past(lane_base))) == '0));

  assert_none_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((gov_i & lane_base) == '0) |=> (pred_o == '0 && flag_z_o && flag_c_o && !flag_n_o));

  assert_true_lane_clears_z_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_n_o || !flag_c_o) |-> !flag_z_o);
endmodule

bind vcmp_imm vcmp_imm_chk #(.VLEN(VLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .gov_i(gov_i), .size_i(size_i),
  .pred_o(pred_o), .flag_n_o(flag_n_o), .flag_z_o(flag_z_o),
  .flag_c_o(flag_c_o), .flag_v_o(flag_v_o)
);

// File: tb/vcmp_imm_tb_top.sv
`timescale 1ns/1ps
module vcmp_imm_tb_top;
  localparam int VLEN = 256;
  localparam int PB   = VLEN / 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [VLEN-1:0] vec;
  logic [PB-1:0]   gov;
  logic [1:0]      size;
  logic [3:0]      cond;
  logic [6:0]      imm;
  logic [PB-1:0]   pred;
  logic            fn, fz, fc, fv;
  int              checks = 0;
  int              fails  = 0;

  always #4 clk = ~clk;

  vcmp_imm #(.VLEN(VLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .vec_i(vec), .gov_i(gov), .size_i(size),
    .cond_i(cond), .imm_i(imm), .pred_o(pred), .flag_n_o(fn),
    .flag_z_o(fz), .flag_c_o(fc), .flag_v_o(fv)
  );

  // fields: size[16:15] cond[14:11] imm[10:4] vsel[3:2] gsel[1:0]
  localparam logic [16:0] TBL [20] = '{
    {2'd0, 4'd0, 7'h07, 2'd0, 2'd0},
    {2'd0, 4'd1, 7'h10, 2'd3, 2'd1},
    {2'd1, 4'd2, 7'h0F, 2'd3, 2'd0},
    {2'd1, 4'd3, 7'h10, 2'd1, 2'd3},
    {2'd2, 4'd4, 7'h00, 2'd3, 2'd0},
    {2'd2, 4'd5, 7'h1F, 2'd1, 2'd1},
    {2'd3, 4'd6, 7'h7F, 2'd1, 2'd0},
    {2'd3, 4'd7, 7'h00, 2'd2, 2'd0},
    {2'd0, 4'd8, 7'h7F, 2'd3, 2'd0},
    {2'd1, 4'd9, 7'h00, 2'd2, 2'd3},
    {2'd3, 4'd4, 7'h10, 2'd1, 2'd0},
    {2'd3, 4'd3, 7'h10, 2'd1, 2'd0},
    {2'd2, 4'd0, 7'h1F, 2'd1, 2'd0},
    {2'd0, 4'd6, 7'h7F, 2'd1, 2'd0},
    {2'd1, 4'd8, 7'h7F, 2'd0, 2'd1},
    {2'd0, 4'd3, 7'h0F, 2'd0, 2'd2},
    {2'd2, 4'd9, 7'h7F, 2'd0, 2'd3},
    {2'd3, 4'd1, 7'h00, 2'd0, 2'd1},
    {2'd0, 4'd12, 7'h00, 2'd0, 2'd0},
    {2'd3, 4'd2, 7'h70, 2'd3, 2'd0}
  };

  function automatic logic [VLEN-1:0] mkvec(input logic [1:0] s);
    logic [VLEN-1:0] v;
    for (int b = 0; b < PB; b++) begin
      case (s)
        2'd0: v[b*8 +: 8] = 8'(b * 13 + 7);
        2'd1: v[b*8 +: 8] = 8'hFF;
        2'd2: v[b*8 +: 8] = 8'h00;
        default: v[b*8 +: 8] = b[0] ? 8'h80 : 8'h7F;
      endcase
    end
    return v;
  endfunction

  function automatic logic [PB-1:0] mkgov(input logic [1:0] s);
    logic [PB-1:0] g;
    for (int b = 0; b < PB; b++) begin
      case (s)
        2'd0: g[b] = 1'b1;
        2'd1: g[b] = b[0] ? 1'b0 : 1'b1;
        2'd2: g[b] = 1'b0;
        default: g[b] = (b % 5) != 2;
      endcase
    end
    return g;
  endfunction

  // behavioural reference from R1-style lane layout and R2..R10 semantics
  task automatic model(input logic [VLEN-1:0] v, input logic [PB-1:0] g,
                       input logic [1:0] s, input logic [3:0] c, input logic [6:0] k,
                       output logic [PB-1:0] ep, output logic en, ez, ec, ev);
    int ew, nl, bpl;
    bit seen;
    longint signed ks, xs;
    longint unsigned xu, ku;
    bit r;
    ew = 8 << s; nl = VLEN / ew; bpl = ew / 8;
    ep = '0; en = 0; ec = 1; ev = 0; seen = 0;
    ks = k[4] ? longint'(k[4:0]) - 32 : longint'(k[4:0]);
    ku = longint'(k);
    for (int l = 0; l < nl; l++) begin
      xu = 0;
      for (int q = 0; q < ew; q++) xu[q] = v[l*ew + q];
      xs = signed'(xu);
      if (ew < 64 && xu[ew-1]) xs = xs - (longint'(1) << ew);
      case (c)
        0: r = xs == ks;
        1: r = xs != ks;
        2: r = xs > ks;
        3: r = xs >= ks;
        4: r = xs < ks;
        5: r = xs <= ks;
        6: r = xu > ku;
        7: r = xu >= ku;
        8: r = xu < ku;
        9: r = xu <= ku;
        default: r = 0;
      endcase
      if (g[l*bpl]) begin
        ep[l*bpl] = r;
        if (!seen) en = r;
        seen = 1;
        ec = !r;
      end
    end
    ez = (ep == '0);
  endtask

  task automatic check(input string tag, input logic [PB-1:0] ep,
                       input logic en, ez, ec, ev);
    checks++;
    if (pred !== ep || fn !== en || fz !== ez || fc !== ec || fv !== ev) begin
      fails++;
      $display("FAIL %s: got pred=%h nzcv=%b%b%b%b expected pred=%h nzcv=%b%b%b%b",
               tag, pred, fn, fz, fc, fv, ep, en, ez, ec, ev);
    end
  endtask

  task automatic run(input string tag, input logic [VLEN-1:0] v, input logic [PB-1:0] g,
                     input logic [1:0] s, input logic [3:0] c, input logic [6:0] k);
    logic [PB-1:0] ep;
    logic en, ez, ec, ev;
    @(negedge clk);
    vec = v; gov = g; size = s; cond = c; imm = k;
    model(v, g, s, c, k, ep, en, ez, ec, ev);
    @(negedge clk);
    check(tag, ep, en, ez, ec, ev);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [VLEN-1:0] v;
    logic [PB-1:0] g;
    vec = '0; gov = '1; size = 0; cond = 0; imm = 0;
    repeat (3) @(negedge clk);
    check("R11 reset state", '0, 1'b0, 1'b1, 1'b1, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < 20; i++)
      run("R1 R2 R3 R4 table", mkvec(TBL[i][3:2]), mkgov(TBL[i][1:0]),
          TBL[i][16:15], TBL[i][14:11], TBL[i][10:4]);

    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 10; c++)
        for (int t = 0; t < 6; t++) begin
          for (int w = 0; w < VLEN / 32; w++) v[w*32 +: 32] = $urandom;
          for (int w = 0; w < VLEN / 32; w++)
            if ($urandom_range(0, 3) == 0) v[w*32 +: 32] = 32'(int'($urandom_range(0, 40)) - 20);
          g = PB'($urandom);
          run("R1 R2 R7 R8 R9 random", v, g, 2'(s), 4'(c), 7'($urandom));
        end

    // boundary immediates on 64-bit lanes
    run("R3 imm -16 on 64b", {VLEN/64{64'hFFFF_FFFF_FFFF_FFF0}}, '1, 2'd3, 4'd0, 7'h10);
    run("R3 imm 15 on 64b", {VLEN/64{64'd15}}, '1, 2'd3, 4'd5, 7'h0F);
    run("R4 imm 127 on 64b", {VLEN/64{64'd127}}, '1, 2'd3, 4'd7, 7'h7F);
    run("R4 imm 0 lower", mkvec(2'd0), '1, 2'd0, 4'd8, 7'h00);
    // upper immediate bits ignored for signed codes
    run("R3 imm upper bits ignored", {VLEN/64{64'd3}}, '1, 2'd3, 4'd0, 7'h63);
    // governing bits off lane base ignored
    run("R5 upper gov bits", mkvec(2'd1), {PB/4{4'b1110}}, 2'd2, 4'd0, 7'h1F);
    run("R6 slice layout", mkvec(2'd1), '1, 2'd1, 4'd0, 7'h1F);
    run("R10 no active lane", mkvec(2'd1), '0, 2'd0, 4'd1, 7'h00);
    run("R10 only upper gov bits", mkvec(2'd1), {PB/8{8'hFE}}, 2'd3, 4'd1, 7'h00);
    run("R7 single first lane", {{(VLEN-8){1'b1}}, 8'h05}, '1, 2'd0, 4'd0, 7'h05);
    run("R9 last lane true", {8'h05, {(VLEN-8){1'b1}}}, '1, 2'd0, 4'd0, 7'h05);
    run("R2 unused code", mkvec(2'd2), '1, 2'd1, 4'd15, 7'h00);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 reset mid-run", '0, 1'b0, 1'b1, 1'b1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule